// File: doc/BRIEF.md
# Two-Wire Byte-Addressed EEPROM Target

This block is a serial EEPROM target for an I2C/SMBus two-wire bus. It holds a 256-byte array, an 8-bit location pointer and a sticky "touched" flag. The bus lines are sampled with the system clock, so SCL must be slow compared with `clk`: each SCL phase must last at least five clock periods.

The block answers to a 7-bit address equal to a base parameter plus a strap index. Up to eight instances can therefore share one bus. A write transaction moves the pointer and can store bytes. A read transaction streams bytes out from the pointer onward.

When the block receives its write address, it treats the first data byte as a new pointer value. Each later byte is stored at the pointer, and the pointer then steps forward, wrapping at the end of the array. When it receives its read address, it sends the byte at the pointer and steps the pointer, and it keeps doing so for as long as the controller acknowledges. Reset does not keep the array contents: it reloads a computed image into the array.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `accessed` is 0, the pointer is 0, and array byte i holds (IMG_MUL*i + IMG_ADD) mod 256. With the default parameters this is (37*i + 0x5A) mod 256.
- R2: A START followed by an address byte whose upper seven bits differ from the block's address gets no ACK. The block then leaves SDA released for the rest of that transaction, and the transaction changes neither the pointer nor the array.
- R3: In a write transaction (address byte bit 0 = 0), the first byte after the address loads the pointer. A write that carries only this byte leaves the array unchanged.
- R4: Each later byte of the same write is stored at the pointer, and the pointer then increments modulo 256, so a write that starts at 0xFE continues at 0x00.
- R5: The block acknowledges its own address and every byte written to it by pulling SDA low during the ninth clock.
- R6: In a read transaction (address byte bit 0 = 1), each byte is sent MSB first. Each byte is the array byte at the pointer, and the pointer increments after each byte, wrapping from 255 to 0.
- R7: A NACK from the controller after a read byte ends the stream. The block then keeps SDA released until the next START.
- R8: The `accessed` output goes to 1 on any byte written to the block or read from it, and only reset clears it. Traffic for other addresses leaves it unchanged.
- R9: A repeated START is handled the same as a START. A STOP ends the transaction and leaves the pointer unchanged.
- R10: The block's address is BASE_ADDR + `strap_idx`, which is 0x50 to 0x57 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_idx | input | IDX_W | Address offset added to BASE_ADDR |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| accessed | output | 1 | Sticky flag: the block has been read or written |

## Verification
The bench reads 258 bytes in one stream from reset. A pointer that does not wrap, or that increments before it fetches, returns bytes one place off or out of the image. A write that starts at 0xFE checks that storage wraps. If the design treated the first byte as data, it would corrupt location 0xFE or miss the new pointer value.

Every strap value is swept against a band of nearby addresses, each with a trailing data byte. A design with a loose address compare would ACK a neighbour's address, move its pointer, or set `accessed`. Further tests cover an offset-only write, a repeated START that turns a write into a read, a STOP between transactions, and clocking after a NACK. These expose a design that writes on the offset byte, loses the pointer across START or STOP, or keeps driving SDA after the controller ends a read.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_HOLD
   } eep_state_t;

   // Power-on image: byte idx = mul*idx + add, truncated to 8 bits
   function automatic logic [7:0] img_byte(input int unsigned idx,
                                           input logic [7:0] mul,
                                           input logic [7:0] add);
      logic [7:0] lo;
      lo = idx[7:0];
      return 8'(lo * mul + add);
   endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic scl_prev;
   logic sda_prev;

   if (STAGES < 1) begin : g_bad_stages
      $error("eep_line_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_r <= 1'b1;
            sda_r <= 1'b1;
         end else begin
            scl_r <= scl_i;
            sda_r <= sda_i;
         end
      end
      assign scl_q = scl_r;
      assign sda_q = sda_r;
   end else begin : g_chain
      logic [STAGES-1:0] scl_ff, sda_ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
         end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         end
      end
      assign scl_q = scl_ff[STAGES-1];
      assign sda_q = sda_ff[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_q;
         sda_prev <= sda_q;
      end
   end

   assign scl_rise  =  scl_q & ~scl_prev;
   assign scl_fall  = ~scl_q &  scl_prev;
   // SDA edges while SCL stays high frame a transaction
   assign start_det =  scl_q &  scl_prev &  sda_prev & ~sda_q;
   assign stop_det  =  scl_q &  scl_prev & ~sda_prev &  sda_q;

endmodule

// File: rtl/eep_bus_fsm.sv
module eep_bus_fsm
   import eep_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic          sda_q,
   input  logic [6:0]    dev_addr,
   input  logic [DW-1:0] rd_data,
   output logic          sda_oe,
   output logic          wr_stb,
   output logic          wr_first,
   output logic [DW-1:0] wr_byte,
   output logic          rd_stb,
   output eep_state_t    state
);

   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] FULL = CW'(DW);

   if (DW != 8) begin : g_bad_dw
      $error("eep_bus_fsm: the two-wire byte is 8 bits wide");
   end

   logic [CW-1:0] bitcnt;
   logic [DW-1:0] rx_sh;
   logic [DW-1:0] tx_sh;
   logic          rw_bit;
   logic          first_pend;
   logic          ctl_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bitcnt     <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         rw_bit     <= 1'b0;
         first_pend <= 1'b0;
         ctl_ack    <= 1'b0;
         sda_oe     <= 1'b0;
         wr_stb     <= 1'b0;
         wr_first   <= 1'b0;
         wr_byte    <= '0;
         rd_stb     <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (start_det) begin
            state      <= ST_ADDR;
            bitcnt     <= '0;
            sda_oe     <= 1'b0;
            first_pend <= 1'b1;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise && bitcnt != FULL) begin
                     rx_sh  <= {rx_sh[DW-2:0], sda_q};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     bitcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (rx_sh[DW-1:1] == dev_addr) begin
                           sda_oe <= 1'b1;
                           rw_bit <= rx_sh[0];
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state  <= ST_HOLD;
                        end
                     end else begin
                        sda_oe     <= 1'b1;
                        wr_stb     <= 1'b1;
                        wr_byte    <= rx_sh;
                        wr_first   <= first_pend;
                        first_pend <= 1'b0;
                        state      <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw_bit) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[DW-1];
                        rd_stb <= 1'b1;
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise && bitcnt != FULL) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == FULL) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RD_ACK;
                     end else if (bitcnt != '0) begin
                        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                        sda_oe <= ~tx_sh[DW-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ctl_ack <= ~sda_q;
                  end else if (scl_fall) begin
                     if (ctl_ack) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[DW-1];
                        rd_stb <= 1'b1;
                        state  <= ST_RD;
                     end else begin
                        state  <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/eep_store.sv
module eep_store
   import eep_pkg::*;
#(
   parameter int         AW      = 8,
   parameter int         DW      = 8,
   parameter logic [7:0] IMG_MUL = 8'd37,
   parameter logic [7:0] IMG_ADD = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          wr_first,
   input  logic [DW-1:0] wr_byte,
   input  logic          rd_stb,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ptr,
   output logic          accessed
);

   localparam int DEPTH = 1 << AW;

   if (AW > DW) begin : g_bad_aw
      $error("eep_store: pointer must load from one data byte");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= img_byte(i, IMG_MUL, IMG_ADD);
         end
      end else if (wr_stb && !wr_first) begin
         mem[ptr] <= wr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         accessed <= 1'b0;
      end else begin
         if (wr_stb) begin
            accessed <= 1'b1;
            ptr      <= wr_first ? wr_byte[AW-1:0] : ptr + 1'b1;
         end else if (rd_stb) begin
            accessed <= 1'b1;
            ptr      <= ptr + 1'b1;
         end
      end
   end

   assign rd_data = mem[ptr];

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
   import eep_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR   = 7'h50,
   parameter int         IDX_W       = 3,
   parameter int         AW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] IMG_MUL     = 8'd37,
   parameter logic [7:0] IMG_ADD     = 8'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] strap_idx,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic             accessed
);

   localparam int DW      = 8;
   localparam int MAX_DEV = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 3) begin : g_bad_idx
      $error("serial_eeprom_target: IDX_W must be 1..3");
   end
   if (int'(BASE_ADDR) + MAX_DEV > 128) begin : g_bad_base
      $error("serial_eeprom_target: address window leaves 7-bit space");
   end

   logic          sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic [6:0]    dev_addr;
   logic [DW-1:0] rd_data, wr_byte;
   logic          wr_stb, wr_first, rd_stb;
   logic [AW-1:0] ptr;
   eep_state_t    state;

   assign dev_addr = BASE_ADDR + 7'(strap_idx);

   eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   eep_bus_fsm #(.DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_q     (sda_q),
      .dev_addr  (dev_addr),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_first  (wr_first),
      .wr_byte   (wr_byte),
      .rd_stb    (rd_stb),
      .state     (state)
   );

   eep_store #(
      .AW      (AW),
      .DW      (DW),
      .IMG_MUL (IMG_MUL),
      .IMG_ADD (IMG_ADD)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_first (wr_first),
      .wr_byte  (wr_byte),
      .rd_stb   (rd_stb),
      .rd_data  (rd_data),
      .ptr      (ptr),
      .accessed (accessed)
   );

endmodule

// File: rtl/eep_chk.sv
module eep_chk
   import eep_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_oe,
   input logic          accessed,
   input logic          wr_stb,
   input logic          wr_first,
   input logic [7:0]    wr_byte,
   input logic          rd_stb,
   input logic          stop_det,
   input logic [AW-1:0] ptr,
   input eep_state_t    state
);

   // R8
   acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accessed |=> accessed);

   // R8
   acc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb || rd_stb) |=> accessed);

   // R3
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_first) |=> ptr == AW'($past(wr_byte)));

   // R4
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_first) |=> ptr == AW'($past(ptr) + 1'b1));

   // R6
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> ptr == AW'($past(ptr) + 1'b1));

   // R9
   stop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> $stable(ptr));

   // R5
   wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_oe);

   // R2
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD || state == ST_IDLE) |-> !sda_oe);

   // R5
   addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> sda_oe);

endmodule

bind serial_eeprom_target eep_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe   (sda_oe),
   .accessed (accessed),
   .wr_stb   (wr_stb),
   .wr_first (wr_first),
   .wr_byte  (wr_byte),
   .rd_stb   (rd_stb),
   .stop_det (stop_det),
   .ptr      (ptr),
   .state    (state)
);

// File: tb/serial_eeprom_target_tb.sv
`timescale 1ns/1ps
module serial_eeprom_target_tb;

   localparam int HP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'd0;
   logic       m_scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_line;
   logic       sda_oe, accessed;
   bit         done = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] mdl_mem [256];
   logic [7:0] mdl_ptr;

   always #2 clk = ~clk;

   assign sda_line = ~(m_low | sda_oe);

   serial_eeprom_target u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_idx (strap),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .accessed  (accessed)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_scl = 1'b1;
      m_low = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(4);
      for (int i = 0; i < 256; i++) mdl_mem[i] = 8'((37 * i + 90) % 256);
      mdl_ptr = 8'd0;
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_low = 1'b1; tick(HP);
      m_scl = 1'b0; tick(HP);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_low = 1'b0; tick(HP);
   endtask

   task automatic bit_out(input logic b);
      m_low = ~b; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_scl = 1'b0; tick(HP);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      m_low = 1'b0; tick(HP);
      m_scl = 1'b1; tick(HP);
      acked = ~sda_line;
      m_scl = 1'b0; tick(HP);
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] d);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(HP);
         m_scl = 1'b1; tick(HP);
         d[i] = sda_line;
         m_scl = 1'b0;
      end
      tick(HP);
      m_low = ~nack; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_scl = 1'b0; tick(HP);
      m_low = 1'b0;
   endtask

   // read n bytes after an already-sent read address; last one NACKed
   task automatic read_run(input int n, input string tag);
      logic [7:0] d;
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, d);
         chk(d == mdl_mem[mdl_ptr], tag, d, mdl_mem[mdl_ptr]);
         mdl_ptr = mdl_ptr + 8'd1;
      end
   endtask

   task automatic addr_phase(input logic [6:0] a, input bit rd, input bit expect_ack, input string tag);
      bit ak;
      send_byte({a, rd}, ak);
      chk(ak == expect_ack, tag, ak, expect_ack);
   endtask

   task automatic wr_bytes(input logic [7:0] b, input bit is_offset);
      bit ak;
      send_byte(b, ak);
      // R5 every written byte is acknowledged
      chk(ak, "R5 write byte ack", ak, 1);
      if (is_offset) mdl_ptr = b;
      else begin
         mdl_mem[mdl_ptr] = b;
         mdl_ptr = mdl_ptr + 8'd1;
      end
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      bit ak;
      do_reset();
      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
      chk(accessed == 1'b0, "R1 accessed clear", accessed, 0);

      // R6 R1 full stream from pointer 0, wrapping past 255
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R5 R10 read address ack");
      read_run(258, "R6 stream image");
      // R7 after NACK the block stays off SDA
      recv_byte(1'b1, d);
      chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
      bus_stop();
      chk(accessed == 1'b1, "R8 set by read", accessed, 1);

      // R4 write wraps from 0xFE through 0x01
      bus_start();
      addr_phase(7'h50, 1'b0, 1'b1, "R5 write address ack");
      wr_bytes(8'hFE, 1'b1);
      wr_bytes(8'hA1, 1'b0);
      wr_bytes(8'hB2, 1'b0);
      wr_bytes(8'hC3, 1'b0);
      wr_bytes(8'hD4, 1'b0);
      bus_stop();
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R5 read address ack");
      read_run(1, "R4 pointer after wrap");
      bus_stop();
      bus_start();
      addr_phase(7'h50, 1'b0, 1'b1, "R5 write address ack");
      wr_bytes(8'hFE, 1'b1);
      bus_stop();
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R5 read address ack");
      read_run(4, "R4 wrapped data");
      bus_stop();

      // R3 offset-only write moves pointer, array unchanged
      bus_start();
      addr_phase(7'h50, 1'b0, 1'b1, "R5 write address ack");
      wr_bytes(8'h10, 1'b1);
      bus_stop();
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R5 read address ack");
      read_run(2, "R3 offset only");
      bus_stop();

      // R9 repeated start turns write into read; stop keeps pointer
      bus_start();
      addr_phase(7'h50, 1'b0, 1'b1, "R5 write address ack");
      wr_bytes(8'h40, 1'b1);
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R9 repeated start ack");
      read_run(2, "R9 read after repeated start");
      bus_stop();
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R9 read address ack");
      read_run(1, "R9 pointer kept over stop");
      bus_stop();

      // R1 reset reloads image over written bytes
      do_reset();
      bus_start();
      addr_phase(7'h50, 1'b0, 1'b1, "R5 write address ack");
      wr_bytes(8'hFE, 1'b1);
      bus_start();
      addr_phase(7'h50, 1'b1, 1'b1, "R5 read address ack");
      read_run(4, "R1 image restored");
      bus_stop();

      // R2 R8 R10 address sweep for each strap value
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         do_reset();
         chk(accessed == 1'b0, "R1 accessed after reset", accessed, 0);
         for (int a = 8'h4F; a <= 8'h58; a++) begin
            if (a != 8'h50 + s) begin
               bus_start();
               addr_phase(7'(a), 1'b0, 1'b0, "R2 R10 foreign address no ack");
               send_byte(8'h33, ak);
               chk(!ak, "R2 foreign data no ack", ak, 0);
               bus_stop();
            end
         end
         chk(accessed == 1'b0, "R8 untouched by foreign", accessed, 0);
         if (s % 2 == 1) begin
            bus_start();
            addr_phase(7'(8'h50 + s), 1'b0, 1'b1, "R10 own write address ack");
            wr_bytes(8'h00, 1'b1);
            bus_stop();
            chk(accessed == 1'b1, "R8 set by write", accessed, 1);
         end
         bus_start();
         addr_phase(7'(8'h50 + s), 1'b1, 1'b1, "R10 own read address ack");
         read_run(1, "R2 pointer untouched by foreign");
         bus_stop();
         chk(accessed == 1'b1, "R8 set after read", accessed, 1);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule